// File: doc/BRIEF.md
# Interrupt Affinity Routing Register Bank

This block holds one 64-bit routing register for every shared peripheral interrupt and sits on a simple memory-mapped bus. Software can reach each register with 32-bit or 64-bit transfers. Only a 24-bit, three-level affinity value is stored in each register. The upper 32-bit half of every register reads as zero and ignores writes. The register of interrupt `n` sits at byte offset `n*8`, so the interrupt number is taken from address bits above bit 2. Address bit 2 selects the upper half.

Each accepted write also resolves the new affinity to a target CPU. The bank compares the affinity against a per-CPU identifier table, which is a configuration input. It stores the matching CPU index together with a valid flag. When no identifier matches, the target is marked invalid; it does not fall back to CPU 0. A separate query port returns the stored target of any interrupt number. Private interrupt numbers and numbers at or above the configured count have no storage: they read as zero, ignore writes and report no target. The bank does not deliver interrupts and does not arbitrate between them.

Top module: `irq_route_bank`

## Requirements
- R1: After reset every stored affinity is zero. One cycle after the internal reset release, every stored target holds the result of resolving the value zero against the CPU table.
- R2: A write to the lower half of a valid register keeps only write-data bits 23:0 and discards all other bits. This holds for both 32-bit and 64-bit transfers.
- R3: Any access with address bit 2 set targets the upper half. Such an access reads as zero and changes neither the stored affinity nor the target.
- R4: A read returns the stored 64-bit value (affinity in bits 23:0, zero above) shifted right by eight times address bits 2:0. A 32-bit read (`req_size`=0) keeps only the low 32 bits of that result; a 64-bit read (`req_size`=1) keeps all 64.
- R5: A 32-bit write at byte offset 0 fully replaces the stored affinity with write-data bits 23:0.
- R6: Interrupt numbers below NUM_PRIV (default 32) read as zero and ignore writes.
- R7: Interrupt numbers at or above NUM_IRQ (default 64) read as zero and ignore writes. Such a write does not alias onto any stored slot.
- R8: After each accepted write, the stored target becomes the index of the lowest-numbered CPU whose 24-bit table entry equals the new affinity. CPU `i` occupies bits `i*24+23 : i*24` of `cpu_aff_tbl`.
- R9: If no table entry equals the written affinity, the query port reports `qry_hit`=0 and `qry_cpu`=0 for that interrupt.
- R10: A read request produces `rsp_valid`=1 with its data exactly one cycle later. `rsp_valid` is 0 in every other cycle.
- R11: A query of a private or out-of-range interrupt number returns `qry_hit`=0 and `qry_cpu`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = 32-bit transfer, 1 = 64-bit transfer |
| req_addr | input | ADDR_W (13) | Byte offset within the region |
| req_wdata | input | 64 | Write data, lower half in bits 31:0 |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 64 | Read data |
| cpu_aff_tbl | input | NUM_CPU*24 (96) | Per-CPU affinity identifiers |
| qry_irq | input | ID_W (10) | Interrupt number whose target is looked up |
| qry_hit | output | 1 | Target of the queried interrupt is valid |
| qry_cpu | output | CPU_W (2) | Target CPU index of the queried interrupt |

## Verification
Writes use affinity values that each match a different CPU entry, including the entry equal to zero. Another value matches no entry. Together these show whether the resolver picks the right index, whether it invents a default, and whether the reset-time resolution ran. Writes carry ones in every discarded bit and arrive at both transfer sizes, so masking faults and size-dependent faults both show up. Accesses aimed at the upper half, at private numbers, at the last valid number and just past it show whether the address decode separates storage from read-as-zero space. This includes the out-of-range number that would alias onto the first slot if the index were truncated.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int AFF_W  = 24;
  localparam int BUS_W  = 64;
  localparam int WORD_W = 32;

  // Shift a 64-bit value right by the byte offset; narrow transfers keep the low word.
  function automatic logic [BUS_W-1:0] pick_bytes(input logic [BUS_W-1:0] v,
                                                  input logic [2:0]       off,
                                                  input logic             wide);
    logic [BUS_W-1:0] sh;
    sh = v >> {off, 3'b000};
    return wide ? sh : {{(BUS_W-WORD_W){1'b0}}, sh[WORD_W-1:0]};
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_route_decode.sv
module irq_route_decode #(
  parameter int ADDR_W   = 13,
  parameter int SLOT_W   = 5,
  parameter int NUM_IRQ  = 64,
  parameter int NUM_PRIV = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              upper,
  output logic              in_bank,
  output logic [SLOT_W-1:0] slot
);
  localparam int ID_W = ADDR_W - 3;

  logic [ID_W-1:0] id;
  logic [ID_W-1:0] rel;
  logic            unused_low;

  assign id         = addr[ADDR_W-1:3];
  assign upper      = addr[2];
  assign unused_low = ^addr[1:0];
  assign rel        = id - ID_W'(NUM_PRIV);
  assign in_bank    = (id >= ID_W'(NUM_PRIV)) && (id < ID_W'(NUM_IRQ));
  assign slot       = rel[SLOT_W-1:0];
endmodule

// File: rtl/irq_aff_resolver.sv
module irq_aff_resolver #(
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = 2,
  parameter int AFF_W   = 24
) (
  input  logic [NUM_CPU*AFF_W-1:0] tbl,
  input  logic [AFF_W-1:0]         aff,
  output logic                     hit,
  output logic [CPU_W-1:0]         cpu
);
  logic [NUM_CPU-1:0] eq;

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cmp
    assign eq[g] = (tbl[g*AFF_W +: AFF_W] == aff);
  end

  // Lowest index wins: scan downward so the last assignment is the smallest match.
  always_comb begin
    cpu = '0;
    for (int i = NUM_CPU - 1; i >= 0; i--) begin
      if (eq[i]) cpu = CPU_W'(i);
    end
  end

  assign hit = |eq;
endmodule

// File: rtl/irq_route_store.sv
module irq_route_store #(
  parameter int NSLOT  = 32,
  parameter int SLOT_W = 5,
  parameter int CPU_W  = 2,
  parameter int AFF_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [AFF_W-1:0]  wr_aff,
  input  logic              wr_hit,
  input  logic [CPU_W-1:0]  wr_cpu,
  input  logic              zero_hit,
  input  logic [CPU_W-1:0]  zero_cpu,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [AFF_W-1:0]  rd_aff,
  input  logic [SLOT_W-1:0] q_slot,
  output logic              q_hit,
  output logic [CPU_W-1:0]  q_cpu
);
  logic [NSLOT-1:0][AFF_W-1:0] aff_q, aff_d;
  logic [NSLOT-1:0]            hit_q, hit_d;
  logic [NSLOT-1:0][CPU_W-1:0] cpu_q, cpu_d;
  logic                        upd_en;

  assign upd_en = wr_en | init;

  always_comb begin
    aff_d = aff_q;
    hit_d = hit_q;
    cpu_d = cpu_q;
    if (init) begin
      for (int s = 0; s < NSLOT; s++) begin
        hit_d[s] = zero_hit;
        cpu_d[s] = zero_cpu;
      end
    end
    if (wr_en) begin
      aff_d[wr_slot] = wr_aff;
      hit_d[wr_slot] = wr_hit;
      cpu_d[wr_slot] = wr_cpu;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aff_q <= '0;
      hit_q <= '0;
      cpu_q <= '0;
    end else if (upd_en) begin
      aff_q <= aff_d;
      hit_q <= hit_d;
      cpu_q <= cpu_d;
    end
  end

  assign rd_aff = aff_q[rd_slot];
  assign q_hit  = hit_q[q_slot];
  assign q_cpu  = hit_q[q_slot] ? cpu_q[q_slot] : '0;

  // R3 R6 R7: no accepted write means no stored affinity changes
  aff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(aff_q));

  // R2: an accepted write lands in its slot
  aff_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> aff_q[$past(wr_slot)] == $past(wr_aff));
endmodule

// File: rtl/irq_route_bank.sv
module irq_route_bank #(
  parameter int NUM_IRQ  = 64,
  parameter int NUM_PRIV = 32,
  parameter int ID_SPACE = 1024,
  parameter int NUM_CPU  = 4,
  parameter int ADDR_W   = $clog2(ID_SPACE * 8),
  parameter int ID_W     = ADDR_W - 3,
  parameter int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic                   req_size,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [63:0]            req_wdata,
  output logic                   rsp_valid,
  output logic [63:0]            rsp_rdata,
  input  logic [NUM_CPU*24-1:0]  cpu_aff_tbl,
  input  logic [ID_W-1:0]        qry_irq,
  output logic                   qry_hit,
  output logic [CPU_W-1:0]       qry_cpu
);
  import irq_route_pkg::*;

  localparam int NSLOT  = NUM_IRQ - NUM_PRIV;
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic              rst_sync_n;
  logic              init_q;
  logic              acc_upper, acc_in_bank;
  logic [SLOT_W-1:0] acc_slot;
  logic              rd_fire, wr_en;
  logic [AFF_W-1:0]  wr_aff, rd_aff;
  logic              wr_hit, zero_hit;
  logic [CPU_W-1:0]  wr_cpu, zero_cpu;
  logic [SLOT_W-1:0] q_slot;
  logic [ID_W-1:0]   q_rel;
  logic              q_in_bank, st_hit;
  logic [CPU_W-1:0]  st_cpu;
  logic [BUS_W-1:0]  rdata_d;
  logic              unused_wdata_hi;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // One-shot after reset: resolve the zero affinity into every slot's target.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  init_q <= 1'b1;
    else if (init_q)  init_q <= 1'b0;
  end

  irq_route_decode #(
    .ADDR_W   (ADDR_W),
    .SLOT_W   (SLOT_W),
    .NUM_IRQ  (NUM_IRQ),
    .NUM_PRIV (NUM_PRIV)
  ) u_dec (
    .addr    (req_addr),
    .upper   (acc_upper),
    .in_bank (acc_in_bank),
    .slot    (acc_slot)
  );

  assign rd_fire         = req_valid & ~req_write;
  assign wr_en           = req_valid & req_write & acc_in_bank & ~acc_upper;
  assign wr_aff          = req_wdata[AFF_W-1:0];
  assign unused_wdata_hi = ^req_wdata[63:AFF_W];

  irq_aff_resolver #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .AFF_W(AFF_W)) u_res_wr (
    .tbl (cpu_aff_tbl),
    .aff (wr_aff),
    .hit (wr_hit),
    .cpu (wr_cpu)
  );

  irq_aff_resolver #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .AFF_W(AFF_W)) u_res_zero (
    .tbl (cpu_aff_tbl),
    .aff ('0),
    .hit (zero_hit),
    .cpu (zero_cpu)
  );

  assign q_rel     = qry_irq - ID_W'(NUM_PRIV);
  assign q_slot    = q_rel[SLOT_W-1:0];
  assign q_in_bank = (qry_irq >= ID_W'(NUM_PRIV)) && (qry_irq < ID_W'(NUM_IRQ));

  irq_route_store #(
    .NSLOT  (NSLOT),
    .SLOT_W (SLOT_W),
    .CPU_W  (CPU_W),
    .AFF_W  (AFF_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .init     (init_q),
    .wr_en    (wr_en),
    .wr_slot  (acc_slot),
    .wr_aff   (wr_aff),
    .wr_hit   (wr_hit),
    .wr_cpu   (wr_cpu),
    .zero_hit (zero_hit),
    .zero_cpu (zero_cpu),
    .rd_slot  (acc_slot),
    .rd_aff   (rd_aff),
    .q_slot   (q_slot),
    .q_hit    (st_hit),
    .q_cpu    (st_cpu)
  );

  assign qry_hit = q_in_bank & st_hit;
  assign qry_cpu = q_in_bank ? st_cpu : '0;

  // Read data next state: only lower half of a stored slot returns data.
  always_comb begin
    rdata_d = '0;
    if (acc_in_bank && !acc_upper)
      rdata_d = pick_bytes({{(BUS_W-AFF_W){1'b0}}, rd_aff}, req_addr[2:0], req_size);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_rdata <= rdata_d;
    end
  end

  // R10
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_fire |=> rsp_valid);

  // R10
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_fire |=> !rsp_valid);

  // R3
  upper_raz_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_fire && req_addr[2]) |=> (rsp_rdata == '0));

  // R11
  qry_private_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (qry_irq < ID_W'(NUM_PRIV)) |-> (!qry_hit && qry_cpu == '0));
endmodule

// File: tb/irq_route_bank_tb.sv
`timescale 1ns/1ps
module irq_route_bank_tb;
  localparam int ADDR_W = 13;
  localparam int ID_W   = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_size;
  logic [12:0] req_addr;
  logic [63:0] req_wdata;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic [95:0] cpu_aff_tbl;
  logic [9:0]  qry_irq;
  logic        qry_hit;
  logic [1:0]  qry_cpu;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  irq_route_bank u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cpu_aff_tbl(cpu_aff_tbl),
    .qry_irq(qry_irq), .qry_hit(qry_hit), .qry_cpu(qry_cpu)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int irq, input bit hi, input bit wide, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = wide;
    req_addr  = ADDR_W'(irq * 8 + (hi ? 4 : 0));
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input int irq, input bit hi, input bit wide, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = wide;
    req_addr  = ADDR_W'(irq * 8 + (hi ? 4 : 0));
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 rsp_valid after read", 64'(rsp_valid), 64'd1);
    d = rsp_rdata;
  endtask

  task automatic query(input int irq, input bit exp_hit, input logic [1:0] exp_cpu, input string tag);
    @(negedge clk);
    qry_irq = ID_W'(irq);
    #1;
    check({tag, " hit"}, 64'(qry_hit), 64'(exp_hit));
    check({tag, " cpu"}, 64'(qry_cpu), 64'(exp_cpu));
  endtask

  task automatic t_reset();
    logic [63:0] d;
    bus_read(32, 0, 1, d);  check("R1 reset affinity irq32", d, 64'h0);
    bus_read(63, 0, 0, d);  check("R1 reset affinity irq63", d, 64'h0);
    query(40, 1'b1, 2'd2, "R1 reset target resolves zero to cpu2");
    @(negedge clk);
    check("R10 rsp_valid idle", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_write_wide();
    logic [63:0] d;
    bus_write(33, 0, 1, 64'hFFFF_FFFF_FF01_0203);
    bus_read(33, 0, 1, d);  check("R2 64-bit write keeps 23:0", d, 64'h0001_0203);
    bus_read(33, 0, 0, d);  check("R4 32-bit read offset 0", d, 64'h0001_0203);
    query(33, 1'b1, 2'd3, "R8 target cpu3");
  endtask

  task automatic t_write_narrow();
    logic [63:0] d;
    bus_write(34, 0, 0, 64'hDEAD_BEEF_AB00_0101);
    bus_read(34, 0, 1, d);  check("R5 32-bit write replaces affinity", d, 64'h0000_0101);
    query(34, 1'b1, 2'd1, "R8 target cpu1");
  endtask

  task automatic t_upper();
    logic [63:0] d;
    bus_write(34, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_write(34, 1, 1, 64'h0000_0000_0001_0203);
    bus_read(34, 1, 0, d);  check("R3 upper word reads zero", d, 64'h0);
    bus_read(34, 1, 1, d);  check("R3 upper wide read zero", d, 64'h0);
    bus_read(34, 0, 1, d);  check("R3 upper writes ignored", d, 64'h0000_0101);
    query(34, 1'b1, 2'd1, "R3 target unchanged");
  endtask

  task automatic t_nomatch();
    logic [63:0] d;
    bus_write(35, 0, 1, 64'h0000_0000_0000_AA55);
    query(35, 1'b0, 2'd0, "R9 unmatched affinity invalid");
    bus_read(35, 0, 1, d);  check("R4 unmatched value reads back", d, 64'hAA55);
    bus_write(35, 0, 0, 64'h0000_0000_0000_0100);
    query(35, 1'b1, 2'd0, "R8 rewrite resolves cpu0");
  endtask

  task automatic t_private();
    logic [63:0] d;
    bus_write(5, 0, 1, 64'h0001_0203);
    bus_read(5, 0, 1, d);   check("R6 private reads zero", d, 64'h0);
    query(5, 1'b0, 2'd0, "R11 private query invalid");
    bus_write(31, 0, 0, 64'h0000_0101);
    bus_read(31, 0, 0, d);  check("R6 irq31 reads zero", d, 64'h0);
  endtask

  task automatic t_range();
    logic [63:0] d;
    bus_write(63, 0, 1, 64'h0001_0101);
    bus_read(63, 0, 1, d);  check("R7 last valid irq stores", d, 64'h0001_0101);
    bus_write(64, 0, 1, 64'h0000_AA55);
    bus_read(64, 0, 1, d);  check("R7 irq64 reads zero", d, 64'h0);
    bus_read(32, 0, 1, d);  check("R7 irq64 write no alias onto irq32", d, 64'h0);
    query(32, 1'b1, 2'd2, "R7 irq32 target untouched");
    query(64, 1'b0, 2'd0, "R11 out-of-range query invalid");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 1'b0;
    req_addr = '0; req_wdata = '0; qry_irq = '0;
    cpu_aff_tbl = {24'h010203, 24'h000000, 24'h000101, 24'h000100};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_wide();
    t_write_narrow();
    t_upper();
    t_nomatch();
    t_private();
    t_range();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule